// File: doc/BRIEF.md
# Register-Amount Shifter with Carry Out

This block is a 32-bit combinational shifter for an integer datapath. The shift distance comes from a register operand. Only the lowest byte of that operand counts, so distances from 0 to 255 are possible. The block performs one of four operations on the data word and returns the shifted word together with a new carry flag. The carry follows exact rules for a distance of zero, a distance of exactly 32, distances beyond 32, and rotations by whole multiples of the word width.

The caller drives the data word, the amount word, a 2-bit operation code and the present carry flag. The result and the updated carry appear in the same cycle, with no register inside the block.

Top module: `reg_shifter`

## Requirements
- R1: Bits 31:8 of `amt_i` have no effect on either output. The shift distance n is `amt_i[7:0]`.
- R2: When n is 0, for every operation, `res_o` equals `opd_i` and `carry_o` equals `carry_i`.
- R3: For a logical left shift (op code 0) with n from 1 to 31, `res_o` is `opd_i` shifted left by n with zeros filled in. `carry_o` is `opd_i[32-n]`.
- R4: For a logical left shift with n equal to 32, `res_o` is 0 and `carry_o` is `opd_i[0]`.
- R5: For a logical left shift with n from 33 to 255, `res_o` and `carry_o` are both 0.
- R6: For a logical right shift (op code 1) with n from 1 to 31, `res_o` is `opd_i` shifted right by n with zeros filled in. `carry_o` is `opd_i[n-1]`.
- R7: For a logical right shift with n equal to 32, `res_o` is 0 and `carry_o` is `opd_i[31]`.
- R8: For a logical right shift with n from 33 to 255, `res_o` and `carry_o` are both 0.
- R9: For an arithmetic right shift (op code 2) with n from 1 to 31, the vacated upper bits of `res_o` copy `opd_i[31]`. `carry_o` is `opd_i[n-1]`.
- R10: For an arithmetic right shift with n from 32 to 255, every bit of `res_o` and `carry_o` equals `opd_i[31]`.
- R11: For a rotate right (op code 3), let r be n modulo 32. When r is non-zero, `res_o` is `opd_i` rotated right by r, and `carry_o` is `opd_i[r-1]`, which is the same bit as `res_o[31]`.
- R12: For a rotate right with n non-zero and r zero (n = 32, 64, ... 224), `res_o` equals `opd_i` and `carry_o` is `opd_i[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | 32 | Data word to shift |
| amt_i | input | 32 | Amount word; only bits 7:0 are used |
| op_i | input | 2 | Operation: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Shifted result |
| carry_o | output | 1 | Updated carry flag |

## Verification
The embedded immediate checks assume that all inputs carry known two-state values and that they change together, so the outputs settle from one consistent set of inputs. The bench meets this in two ways. It drives every input from a single task in the same time step. It then waits a fixed delay before it samples the outputs. The amount byte is swept across all 256 values, and the upper amount bits are loaded with random junk. This junk reaches the checks without affecting them.

// File: rtl/reg_shifter.sv
module reg_shifter #(
  parameter int W = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  opd_i,
  input  logic [W-1:0]  amt_i,
  input  logic [1:0]    op_i,
  input  logic          carry_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o
);
  localparam int RW = $clog2(W);

  logic [AW-1:0] n;
  logic [RW-1:0] r;
  logic          unused_amt_hi;
  logic [W:0]    lsl_w, lsr_w, asr_w;
  logic [2*W-1:0] ror_w;
  logic [AW-1:0] asr_n;

  assign n = amt_i[AW-1:0];
  assign r = n[RW-1:0];
  assign unused_amt_hi = ^amt_i[W-1:AW];
  assign asr_n = (n > AW'(W)) ? AW'(W) : n;

  always_comb begin
    lsl_w = ({1'b0, opd_i} << n);
    lsr_w = ({opd_i, 1'b0} >> n);
    asr_w = $unsigned($signed({opd_i, 1'b0}) >>> asr_n);
    ror_w = {opd_i, opd_i} >> r;
    res_o = opd_i;
    carry_o = carry_i;
    if (n != '0) begin
      unique case (op_i)
        2'd0: begin
          res_o = lsl_w[W-1:0];
          carry_o = (n > AW'(W)) ? 1'b0 : lsl_w[W];
        end
        2'd1: begin
          res_o = lsr_w[W:1];
          carry_o = (n > AW'(W)) ? 1'b0 : lsr_w[0];
        end
        2'd2: begin
          res_o = asr_w[W:1];
          carry_o = asr_w[0];
        end
        default: begin
          res_o = ror_w[W-1:0];
          carry_o = ror_w[W-1];
        end
      endcase
    end
  end

  always_comb begin
    if (n == '0) begin
      // R2
      zero_pass_chk: assert (res_o == opd_i && carry_o == carry_i)
        else $error("zero amount altered outputs");
    end
    if (op_i != 2'd2 && op_i != 2'd3 && n > AW'(W)) begin
      // R5 R8
      far_logical_chk: assert (res_o == '0 && carry_o == 1'b0)
        else $error("logical shift beyond width not cleared");
    end
    if (op_i == 2'd2 && n >= AW'(W)) begin
      // R10
      asr_fill_chk: assert (res_o == {W{opd_i[W-1]}} && carry_o == opd_i[W-1])
        else $error("arithmetic shift fill wrong");
    end
    if (op_i == 2'd3 && n != '0) begin
      // R11 R12
      ror_bits_chk: assert ($countones(res_o) == $countones(opd_i) && carry_o == res_o[W-1])
        else $error("rotate lost bits or carry");
    end
  end
endmodule

// File: tb/test_reg_shifter.sv
module test_reg_shifter;
  logic        clk = 1'b0;
  logic [31:0] opd, amt;
  logic [1:0]  op;
  logic        cin;
  logic [31:0] res;
  logic        cout;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reg_shifter i_reg_shifter (
    .opd_i(opd), .amt_i(amt), .op_i(op), .carry_i(cin),
    .res_o(res), .carry_o(cout)
  );

  function automatic logic [32:0] model(input logic [1:0] o, input logic [31:0] d,
                                        input logic [31:0] a, input logic c);
    logic [31:0] v = d;
    logic cc = c;
    for (int k = 0; k < int'(a[7:0]); k++) begin
      case (o)
        2'd0: begin cc = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin cc = v[0]; v = {1'b0, v[31:1]}; end
        2'd2: begin cc = v[0]; v = {v[31], v[31:1]}; end
        default: begin cc = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {cc, v};
  endfunction

  task automatic apply(input string tag, input logic [1:0] o, input logic [31:0] d,
                       input logic [31:0] a, input logic c);
    logic [32:0] exp;
    opd = d; amt = a; op = o; cin = c;
    #3;
    exp = model(o, d, {24'd0, a[7:0]}, c);
    total++;
    if ({cout, res} !== exp) begin
      bad++;
      $display("FAIL %s op=%0d d=%h n=%0d: got c=%b r=%h exp c=%b r=%h",
               tag, o, d, a[7:0], cout, res, exp[32], exp[31:0]);
    end
  endtask

  task automatic t_reset;
    opd = 0; amt = 0; op = 0; cin = 0;
    #3;
    total++;
    if (res !== 0 || cout !== 0) begin
      bad++;
      $display("FAIL R2 idle: got c=%b r=%h exp c=0 r=0", cout, res);
    end
  endtask

  task automatic t_zero;
    for (int o = 0; o < 4; o++) begin
      apply("R2", 2'(o), 32'hA5C3_0F71, 32'h0, 1'b1);
      apply("R2", 2'(o), 32'h8000_0001, 32'h1234_5600, 1'b0);
    end
  endtask

  task automatic t_upper;
    for (int o = 0; o < 4; o++)
      for (int k = 0; k < 8; k++)
        apply("R1", 2'(o), $urandom, {$urandom_range(32'hFFFFFF, 1), 8'(k * 37)}, k[0]);
  endtask

  task automatic t_lsl;
    apply("R3", 2'd0, 32'h4000_0000, 32'd2, 1'b0);
    apply("R3", 2'd0, 32'h0000_0001, 32'd31, 1'b1);
    apply("R4", 2'd0, 32'h0000_0001, 32'd32, 1'b0);
    apply("R4", 2'd0, 32'hFFFF_FFFE, 32'd32, 1'b1);
    apply("R5", 2'd0, 32'hFFFF_FFFF, 32'd33, 1'b1);
    apply("R5", 2'd0, 32'hFFFF_FFFF, 32'd255, 1'b1);
  endtask

  task automatic t_lsr;
    apply("R6", 2'd1, 32'h0000_0002, 32'd2, 1'b0);
    apply("R6", 2'd1, 32'h8000_0000, 32'd31, 1'b0);
    apply("R7", 2'd1, 32'h8000_0000, 32'd32, 1'b0);
    apply("R7", 2'd1, 32'h7FFF_FFFF, 32'd32, 1'b1);
    apply("R8", 2'd1, 32'hFFFF_FFFF, 32'd33, 1'b1);
    apply("R8", 2'd1, 32'hFFFF_FFFF, 32'd200, 1'b1);
  endtask

  task automatic t_asr;
    apply("R9", 2'd2, 32'h8000_0010, 32'd5, 1'b0);
    apply("R9", 2'd2, 32'h4000_0000, 32'd31, 1'b1);
    apply("R10", 2'd2, 32'h8000_0000, 32'd32, 1'b0);
    apply("R10", 2'd2, 32'h7FFF_FFFF, 32'd32, 1'b1);
    apply("R10", 2'd2, 32'h9000_0000, 32'd255, 1'b0);
  endtask

  task automatic t_ror;
    apply("R11", 2'd3, 32'h0000_0001, 32'd1, 1'b0);
    apply("R11", 2'd3, 32'h1234_5678, 32'd36, 1'b0);
    apply("R11", 2'd3, 32'hF000_000F, 32'd255, 1'b0);
    apply("R12", 2'd3, 32'h8000_0000, 32'd32, 1'b0);
    apply("R12", 2'd3, 32'h7FFF_FFFF, 32'd224, 1'b1);
    apply("R12", 2'd3, 32'hC0DE_1234, 32'd64, 1'b0);
  endtask

  task automatic t_sweep;
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'hAAAA_5555; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h0000_0000; pats[4] = $urandom; pats[5] = $urandom;
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 6; p++)
        for (int k = 0; k < 256; k++)
          apply(o == 0 ? "R3R4R5" : o == 1 ? "R6R7R8" : o == 2 ? "R9R10" : "R11R12",
                2'(o), pats[p], {$urandom_range(255, 0), 24'd0} | 32'(k), p[0]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_zero;
    t_upper;
    t_lsl;
    t_lsr;
    t_asr;
    t_ror;
    t_sweep;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule